// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches a bank of general-purpose input pins for level changes and turns them into a small number of interrupt requests. The pins are split into groups of up to eight. With the default 27 pins there are three full groups of eight and a final group of three. Each pin has its own mask bit. A rising or falling edge on an unmasked pin marks its group as pending in a sticky flag. A group's request line is driven while its flag is pending, its group enable is set and the global interrupt enable input is high.

Each pin first passes through a two-flop synchronizer. A change is then found by comparing the synchronized level with its value one cycle earlier. Each group's flag is a two-state machine. `FLG_IDLE` moves to `FLG_PEND` on a *hit*, which is a qualifying change in the group. `FLG_PEND` returns to `FLG_IDLE` on a *clear*, which is an acknowledge pulse from the interrupt controller or a software write of 1 to the flag bit. It does not return if a hit occurs in the same cycle, because a hit wins over a clear. With no hit and no clear, each state holds.

Software reaches the flags, the enables and the masks over a single-cycle register port. The port has an address select, a write strobe, write data and combinational read data.

Top module: `pcg_top`

## Requirements
- R1: Pin k belongs to group k/8. Group g's pending state reads back at bit g of the flag register, which is at address 0.
- R2: A rising or a falling edge on a pin whose mask bit is 1 sets its group's flag. The pin change must be applied before rising edge n. The flag reads 1 after rising edge n+2 and not earlier.
- R3: `irq_o[g]` is 1 exactly when flag g is 1, bit g of the enable register (address 1) is 1 and `gie_i` is 1.
- R4: An `ack_i[g]` pulse sampled at a rising edge clears flag g at that edge.
- R5: A write to address 0 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R6: A change on a pin whose mask bit is 0 never sets the flag. The mask bit in effect is the one stored before the edge that samples the change.
- R7: Reserved bits always read 0, and writes to them have no effect. These are mask register 3 (address 5) bits 7..3, flag bits 7..4 and enable bits 7..4.
- R8: After reset, every mask, enable and flag bit reads 0 and every request is low.
- R9: If a hit and a clear (acknowledge or write-one) fall on the same edge, the flag is 1 after that edge.
- R10: Address 1 holds the group enables, and addresses 2 to 5 hold the masks of groups 0 to 3. Written values read back on the following cycle. Addresses 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 27 | Asynchronous input pins |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 4 | Per-group service acknowledge pulse |
| bus_sel_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected address |
| irq_o | output | 4 | Per-group interrupt request |

## Verification
A flag stuck in `FLG_PEND` shows on `irq_o` in the first cycle that its enable and `gie_i` are both high. It also shows on a read of address 0 in the same cycle. A flag that misses a hit stays low at the exact edge where the reference model expects it to rise. Wrong timing in the synchronizer or the previous-level register moves that rise by a cycle. A mask or enable bit that is stored wrongly shows as a read-back mismatch on the cycle after the write. The reference model is compared on every clock, so each of these faults is reported within one cycle of the first divergence.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

    localparam int ADDR_FLAG = 0;
    localparam int ADDR_EN   = 1;
    localparam int ADDR_MASK = 2;
endpackage

// File: rtl/pcg_sync.sv
module pcg_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] change_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign change_o = sync_q ^ prev_q;
endmodule

// File: rtl/pcg_group.sv
module pcg_group
    import pcg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] change_i,
    input  logic [W-1:0] mask_i,
    input  logic         clr_i,
    output logic         flag_o
);
    flag_state_e state_q, state_d;
    logic        hit;

    assign hit = |(change_i & mask_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (hit)            state_d = FLG_PEND;
            FLG_PEND: if (clr_i && !hit)  state_d = FLG_IDLE;
            default:                      state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLG_PEND);
    end

    // R2
    set_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state_q == FLG_PEND));

    // R4
    clear_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> (state_q == FLG_IDLE));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && hit) |=> flag_o);
endmodule

// File: rtl/pcg_top.sv
module pcg_top
    import pcg_pkg::*;
#(
    parameter int N_PINS = 27,
    parameter int GRP_W  = 8,
    parameter int ADDR_W = 3,
    parameter int N_GRP  = (N_PINS + GRP_W - 1) / GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    input  logic              gie_i,
    input  logic [N_GRP-1:0]  ack_i,
    input  logic [ADDR_W-1:0] bus_sel_i,
    input  logic              bus_we_i,
    input  logic [GRP_W-1:0]  bus_wdata_i,
    output logic [GRP_W-1:0]  bus_rdata_o,
    output logic [N_GRP-1:0]  irq_o
);
    localparam int N_ADDR = 1 << ADDR_W;

    logic [N_PINS-1:0] change;
    logic [GRP_W-1:0]  mask_q [N_GRP];
    logic [N_GRP-1:0]  en_q;
    logic [N_GRP-1:0]  flag;
    logic [N_GRP-1:0]  clr;
    logic              wr_flag;
    logic              wr_en;

    assign wr_flag = bus_we_i && (bus_sel_i == ADDR_W'(ADDR_FLAG));
    assign wr_en   = bus_we_i && (bus_sel_i == ADDR_W'(ADDR_EN));

    pcg_sync #(.W(N_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .change_o (change)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= bus_wdata_i[N_GRP-1:0];
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam int GW = (g == N_GRP - 1) ? (N_PINS - g * GRP_W) : GRP_W;
        localparam logic [GRP_W-1:0] LIVE = GRP_W'((1 << GW) - 1);

        logic wr_mask;
        assign wr_mask = bus_we_i && (bus_sel_i == ADDR_W'(ADDR_MASK + g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       mask_q[g] <= '0;
            else if (wr_mask) mask_q[g] <= bus_wdata_i & LIVE;
        end

        assign clr[g] = ack_i[g] | (wr_flag & bus_wdata_i[g]);

        pcg_group #(.W(GW)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .change_i (change[g*GRP_W +: GW]),
            .mask_i   (mask_q[g][GW-1:0]),
            .clr_i    (clr[g]),
            .flag_o   (flag[g])
        );
    end

    assign irq_o = flag & en_q & {N_GRP{gie_i}};

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i == ADDR_W'(ADDR_FLAG)) bus_rdata_o[N_GRP-1:0] = flag;
        if (bus_sel_i == ADDR_W'(ADDR_EN))   bus_rdata_o[N_GRP-1:0] = en_q;
        for (int g = 0; g < N_GRP; g++) begin
            if ((ADDR_MASK + g < N_ADDR) && (bus_sel_i == ADDR_W'(ADDR_MASK + g)))
                bus_rdata_o = mask_q[g];
        end
    end

    // R3
    no_irq_without_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> (irq_o == '0));

    // R7
    flag_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i == ADDR_W'(ADDR_FLAG)) |-> (bus_rdata_o[GRP_W-1:N_GRP] == '0));

    // R4
    ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i[0] && change[GRP_W-1:0] == '0) |=> !irq_o[0]);
endmodule

// File: tb/pcg_top_tb.sv
module pcg_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 27;
    localparam int NG = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_i = '0;
    logic          gie_i = 1'b0;
    logic [NG-1:0] ack_i = '0;
    logic [2:0]    bus_sel_i = '0;
    logic          bus_we_i = 1'b0;
    logic [7:0]    bus_wdata_i = '0;
    logic [7:0]    bus_rdata_o;
    logic [NG-1:0] irq_o;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R8";

    // reference model state
    logic [NP-1:0] m_s1, m_s2, m_prev;
    logic [7:0]    m_mask [NG];
    logic [NG-1:0] m_en, m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcg_top u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .gie_i(gie_i), .ack_i(ack_i),
        .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_en = '0; m_flag = '0;
            for (int g = 0; g < NG; g++) m_mask[g] = '0;
        end else begin
            logic [NG-1:0] hit;
            logic [NG-1:0] clrv;
            hit = '0;
            for (int i = 0; i < NP; i++)
                if ((m_s2[i] != m_prev[i]) && m_mask[i/8][i%8]) hit[i/8] = 1'b1;
            clrv = ack_i;
            if (bus_we_i && bus_sel_i == 3'd0) clrv = clrv | bus_wdata_i[NG-1:0];
            m_flag = (m_flag & ~clrv) | hit;
            if (bus_we_i && bus_sel_i == 3'd1) m_en = bus_wdata_i[NG-1:0];
            for (int g = 0; g < NG; g++)
                if (bus_we_i && bus_sel_i == 3'(2 + g))
                    m_mask[g] = (g == 3) ? (bus_wdata_i & 8'h07) : bus_wdata_i;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_i;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {4'h0, m_flag};
            3'd1: return {4'h0, m_en};
            3'd2, 3'd3, 3'd4, 3'd5: return m_mask[a - 3'd2];
            default: return 8'h00;
        endcase
    endfunction

    task automatic compare();
        logic [NG-1:0] ei;
        logic [7:0]    er;
        ei = m_flag & m_en & {NG{gie_i}};
        er = exp_rd(bus_sel_i);
        n_vec++;
        if (irq_o !== ei || bus_rdata_o !== er) begin
            n_bad++;
            $display("FAIL %s: irq=%h rdata=%h expected irq=%h rdata=%h at %0t",
                     cur_req, irq_o, bus_rdata_o, ei, er, $time);
        end
    endtask

    // one cycle: check outputs, then drive the next inputs
    task automatic step(input logic [2:0] sel, input logic we, input logic [7:0] wd,
                        input logic [NG-1:0] ack);
        @(negedge clk);
        compare();
        bus_sel_i = sel; bus_we_i = we; bus_wdata_i = wd; ack_i = ack;
    endtask

    task automatic idle(input int n, input logic [2:0] sel);
        for (int i = 0; i < n; i++) step(sel, 1'b0, 8'h00, '0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(a, 1'b1, d, '0);
    endtask

    task automatic scan_all();
        for (int a = 0; a < 8; a++) step(3'(a), 1'b0, 8'h00, '0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R8"; scan_all();
        gie_i = 1'b1; idle(2, 3'd0);

        cur_req = "R10";
        wr(3'd1, 8'h0F); wr(3'd2, 8'hA5); wr(3'd3, 8'h5A);
        wr(3'd4, 8'hFF); wr(3'd5, 8'h07); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        scan_all();

        cur_req = "R7";
        wr(3'd5, 8'hFF); wr(3'd1, 8'hFF); wr(3'd0, 8'hF0);
        scan_all();

        cur_req = "R2";
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        pin_i[5] = 1'b1; idle(5, 3'd0);
        wr(3'd0, 8'h0F); idle(2, 3'd0);
        pin_i[5] = 1'b0; idle(5, 3'd0);

        cur_req = "R1";
        wr(3'd0, 8'h0F);
        pin_i[26] = 1'b1; idle(5, 3'd0);
        pin_i[9]  = 1'b1; idle(5, 3'd0);
        pin_i[20] = 1'b1; idle(5, 3'd0);

        cur_req = "R5";
        wr(3'd0, 8'h00); idle(2, 3'd0);
        wr(3'd0, 8'h02); idle(2, 3'd0);
        wr(3'd0, 8'h0D); idle(2, 3'd0);

        cur_req = "R6";
        wr(3'd2, 8'h0F);
        pin_i[7] = 1'b1; idle(6, 3'd0);
        pin_i[7] = 1'b0; pin_i[1] = 1'b1; idle(6, 3'd0);
        wr(3'd0, 8'h0F);
        pin_i[6] = 1'b1; idle(1, 3'd0); wr(3'd2, 8'hFF); idle(5, 3'd0);

        cur_req = "R3";
        wr(3'd1, 8'h05); idle(2, 3'd0);
        gie_i = 1'b0; idle(2, 3'd0);
        gie_i = 1'b1; wr(3'd1, 8'h0A); idle(2, 3'd1);
        wr(3'd1, 8'h0F); idle(2, 3'd1);

        cur_req = "R4";
        step(3'd0, 1'b0, 8'h00, 4'b0001); idle(2, 3'd0);
        step(3'd0, 1'b0, 8'h00, 4'b0110); idle(2, 3'd0);
        step(3'd0, 1'b0, 8'h00, 4'b1000); idle(2, 3'd0);

        cur_req = "R9";
        for (int i = 0; i < 12; i++) begin
            pin_i[0] = ~pin_i[0];
            step(3'd0, 1'b0, 8'h00, 4'b0001);
        end
        for (int i = 0; i < 12; i++) begin
            pin_i[25] = ~pin_i[25];
            step(3'd0, 1'b1, 8'h08, '0);
        end
        idle(4, 3'd0);

        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            pin_i = NP'($urandom) & NP'($urandom);
            gie_i = ($urandom_range(0, 7) != 0);
            step(3'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom),
                 4'($urandom) & 4'($urandom));
        end
        idle(4, 3'd0);
        finish_run();
    end
endmodule